// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Register

This block holds the host-visible byte registers of one DMA channel: a status byte, a control (command) byte and a type byte. The host writes commands to start, stop or pause the channel. It clears event bits by writing ones to them. It sets the interrupt enables, the sample format and the auto-start option. The DMA engine next to the block reads the channel state bits and reports its events through single-cycle set pulses: a flagged descriptor, an end of list, and a descriptor stop. The block raises a level interrupt while an enabled event bit is set.

Whether the channel runs is tracked by a three-state sequencer:

- `CH_IDLE`: the channel is inactive.
- `CH_ACTIVE`: the channel is running its list.
- `CH_ARMED`: the channel is active, and a second start command has been queued as a pending trigger.

The transitions are:

- **IDLE-start**: `CH_IDLE` to `CH_ACTIVE`.
- **ACTIVE-start**: `CH_ACTIVE` to `CH_ARMED`.
- **ARMED-start**: `CH_ARMED` stays `CH_ARMED`.
- **stop**: any state goes to `CH_IDLE`.
- **ARMED-eol**: `CH_ARMED` to `CH_ACTIVE`. The trigger is consumed and the list restarts.
- **ACTIVE-eol-auto**: `CH_ACTIVE` stays `CH_ACTIVE` and the list restarts.
- **ACTIVE-eol-finish**: `CH_ACTIVE` to `CH_IDLE`.

In any one cycle the end-of-list event is applied first. The host command is then applied to the result.

The register offsets are: status 0, control 1, type 2. Offset 3 is unused.

Top module: `dmach_ctlreg`

## Requirements
- R1: After reset the status, control and type registers read 0x00, and `irq`, `chan_active`, `chan_pending`, `chan_run` and `ptr_reset` are low.
- R2: A status write clears each of bits 0 (flag event), 1 (end of list) and 2 (halted) that it carries as a 1. It leaves bits 3 (pending trigger), 6 (paused) and 7 (active) unchanged. Status bits 5:4 always read 0.
- R3: The engine pulses set status bits as follows: `ev_flag` sets bits 0 and 2, `ev_eol` sets bit 1, and `ev_stop` sets bit 2. A set pulse wins over a host clear of the same bit in the same cycle.
- R4: A control write with bit 7 set while the channel is idle makes the channel active. It clears the halted bit and pulses `ptr_reset` in the cycle of the write.
- R5: A control write with bit 7 set while the channel is active sets the pending trigger (status bit 3). It does not pulse `ptr_reset`.
- R6: A control write with bit 6 set clears both the active bit and the pending trigger. When bits 7 and 6 are both set, the stop wins.
- R7: Every control write copies its bit 2 into the paused bit (status bit 6). A control read returns only that bit, at position 2.
- R8: The type register keeps bits 7, 5:4 and 1:0 of a write and reads 0 in bits 6, 3 and 2. `fmt` shows bits 5:4 and `autostart` shows bit 7.
- R9: On `ev_eol`: a pending trigger is consumed and the list restarts; otherwise, with auto-start set, the channel stays active and restarts; otherwise the channel goes idle. A restart pulses `ptr_reset` in the cycle of `ev_eol`.
- R10: `irq` is high exactly when (status bits 1:0 AND type bits 1:0) is nonzero. It falls in the cycle after a clear leaves that term at zero.
- R11: `chan_run` is high exactly when the channel is active, not paused and not halted.
- R12: Writes to offset 3 change no register, and reads of offset 3 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write offset |
| wr_data | input | 8 | Write data |
| rd_addr | input | AW | Read offset |
| rd_data | output | 8 | Read data (combinational) |
| ev_flag | input | 1 | Engine pulse: flagged descriptor finished |
| ev_eol | input | 1 | Engine pulse: end of list reached |
| ev_stop | input | 1 | Engine pulse: descriptor stop reached |
| chan_active | output | 1 | Channel active |
| chan_pending | output | 1 | Start trigger queued |
| chan_paused | output | 1 | Host pause bit |
| chan_halted | output | 1 | Halted by an event |
| chan_run | output | 1 | Engine may fetch samples |
| ptr_reset | output | 1 | Restart the list from its first entry |
| fmt | output | 2 | Sample format field |
| autostart | output | 1 | Restart at end of list |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the engine pulses `ev_eol` only while the channel is active, and that each pulse lasts one cycle. The assertions for the stop and queue commands also assume that no end-of-list event falls in the same cycle. The stimulus keeps to these rules: it issues end-of-list pulses only after a start, and it drives each command or event for exactly one clock. The single exception is a deliberate same-cycle set and clear, which checks the priority in R3.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    localparam int DW = 8;

    // status bit positions
    localparam int ST_FLAG  = 0;
    localparam int ST_EOL   = 1;
    localparam int ST_HALT  = 2;
    localparam int ST_TRIG  = 3;
    localparam int ST_PAUSE = 6;
    localparam int ST_ACT   = 7;

    // control bit positions
    localparam int CTL_START = 7;
    localparam int CTL_STOP  = 6;
    localparam int CTL_PAUSE = 2;

    // type register: writable bits
    localparam logic [DW-1:0] TYPE_KEEP = 8'hB3;
    localparam int TY_AUTO  = 7;
    localparam int TY_FMT_L = 4;

    // number of write-one-to-clear event bits
    localparam int N_EVT = 3;

    typedef enum logic [1:0] {
        CH_IDLE   = 2'd0,
        CH_ACTIVE = 2'd1,
        CH_ARMED  = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic             start;
        logic             stop;
        logic             ctl_wr;
        logic             pause_val;
        logic             st_wr;
        logic [N_EVT-1:0] clr;
        logic             type_wr;
        logic [DW-1:0]    type_val;
    } host_cmd_t;

endpackage

// File: rtl/dmach_decode.sv
module dmach_decode
    import dmach_pkg::*;
#(
    parameter int AW          = 2,
    parameter int ADDR_STATUS = 0,
    parameter int ADDR_CTRL   = 1,
    parameter int ADDR_TYPE   = 2
) (
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output host_cmd_t     cmd
);
    localparam logic [AW-1:0] A_ST = AW'(ADDR_STATUS);
    localparam logic [AW-1:0] A_CT = AW'(ADDR_CTRL);
    localparam logic [AW-1:0] A_TY = AW'(ADDR_TYPE);

    logic hit_st, hit_ct, hit_ty;

    always_comb begin
        hit_st = wr_en && (wr_addr == A_ST);
        hit_ct = wr_en && (wr_addr == A_CT);
        hit_ty = wr_en && (wr_addr == A_TY);

        cmd           = '0;
        cmd.st_wr     = hit_st;
        cmd.clr       = hit_st ? wr_data[N_EVT-1:0] : '0;
        cmd.ctl_wr    = hit_ct;
        cmd.start     = hit_ct && wr_data[CTL_START];
        cmd.stop      = hit_ct && wr_data[CTL_STOP];
        cmd.pause_val = wr_data[CTL_PAUSE];
        cmd.type_wr   = hit_ty;
        cmd.type_val  = wr_data & TYPE_KEEP;
    end
endmodule

// File: rtl/dmach_seq.sv
module dmach_seq
    import dmach_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      stop,
    input  logic      ev_eol,
    input  logic      auto_en,
    output logic      active,
    output logic      pending,
    output logic      fresh_start,
    output logic      ptr_reset
);
    ch_state_e state_q, mid_s, state_d;
    logic      eol_restart;
    logic      fresh;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // next state: engine event first, host command on top of it
    always_comb begin
        mid_s       = state_q;
        eol_restart = 1'b0;
        if (ev_eol) begin
            unique case (state_q)
                CH_ARMED: begin
                    mid_s       = CH_ACTIVE;
                    eol_restart = 1'b1;
                end
                CH_ACTIVE: begin
                    if (auto_en) eol_restart = 1'b1;
                    else         mid_s       = CH_IDLE;
                end
                default: mid_s = state_q;
            endcase
        end

        state_d = mid_s;
        fresh   = 1'b0;
        if (start) begin
            unique case (mid_s)
                CH_IDLE: begin
                    state_d = CH_ACTIVE;
                    fresh   = 1'b1;
                end
                default: state_d = CH_ARMED;
            endcase
        end
        if (stop) state_d = CH_IDLE;
    end

    // outputs
    always_comb begin
        active      = (state_q != CH_IDLE);
        pending     = (state_q == CH_ARMED);
        fresh_start = fresh;
        ptr_reset   = fresh | eol_restart;
    end
endmodule

// File: rtl/dmach_flags.sv
module dmach_flags
    import dmach_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  host_cmd_t        cmd,
    input  logic             fresh_start,
    input  logic             ev_flag,
    input  logic             ev_eol,
    input  logic             ev_stop,
    output logic [N_EVT-1:0] evt_bits,
    output logic             paused
);
    logic [N_EVT-1:0] set_v;
    logic [N_EVT-1:0] drop_v;

    always_comb begin
        set_v          = '0;
        set_v[ST_FLAG] = ev_flag;
        set_v[ST_EOL]  = ev_eol;
        set_v[ST_HALT] = ev_flag | ev_stop;
        drop_v         = cmd.clr;
        drop_v[ST_HALT] = cmd.clr[ST_HALT] | fresh_start;
    end

    for (genvar i = 0; i < N_EVT; i++) begin : g_evt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        evt_bits[i] <= 1'b0;
            else if (set_v[i]) evt_bits[i] <= 1'b1;
            else if (drop_v[i]) evt_bits[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          paused <= 1'b0;
        else if (cmd.ctl_wr) paused <= cmd.pause_val;
    end
endmodule

// File: rtl/dmach_ctlreg.sv
module dmach_ctlreg
    import dmach_pkg::*;
#(
    parameter int AW          = 2,
    parameter int ADDR_STATUS = 0,
    parameter int ADDR_CTRL   = 1,
    parameter int ADDR_TYPE   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    input  logic          ev_flag,
    input  logic          ev_eol,
    input  logic          ev_stop,
    output logic          chan_active,
    output logic          chan_pending,
    output logic          chan_paused,
    output logic          chan_halted,
    output logic          chan_run,
    output logic          ptr_reset,
    output logic [1:0]    fmt,
    output logic          autostart,
    output logic          irq
);
    localparam logic [AW-1:0] A_ST = AW'(ADDR_STATUS);
    localparam logic [AW-1:0] A_CT = AW'(ADDR_CTRL);
    localparam logic [AW-1:0] A_TY = AW'(ADDR_TYPE);

    host_cmd_t        cmd;
    logic             fresh_start;
    logic [N_EVT-1:0] evt_bits;
    logic [DW-1:0]    type_q;
    logic [DW-1:0]    status_q;

    dmach_decode #(
        .AW(AW), .ADDR_STATUS(ADDR_STATUS),
        .ADDR_CTRL(ADDR_CTRL), .ADDR_TYPE(ADDR_TYPE)
    ) u_dec (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .cmd    (cmd)
    );

    dmach_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (cmd.start),
        .stop       (cmd.stop),
        .ev_eol     (ev_eol),
        .auto_en    (type_q[TY_AUTO]),
        .active     (chan_active),
        .pending    (chan_pending),
        .fresh_start(fresh_start),
        .ptr_reset  (ptr_reset)
    );

    dmach_flags u_flg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .fresh_start(fresh_start),
        .ev_flag    (ev_flag),
        .ev_eol     (ev_eol),
        .ev_stop    (ev_stop),
        .evt_bits   (evt_bits),
        .paused     (chan_paused)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           type_q <= '0;
        else if (cmd.type_wr) type_q <= cmd.type_val;
    end

    always_comb begin
        status_q           = '0;
        status_q[N_EVT-1:0] = evt_bits;
        status_q[ST_TRIG]  = chan_pending;
        status_q[ST_PAUSE] = chan_paused;
        status_q[ST_ACT]   = chan_active;
    end

    always_comb begin
        chan_halted = evt_bits[ST_HALT];
        chan_run    = chan_active & ~chan_paused & ~chan_halted;
        fmt         = type_q[TY_FMT_L +: 2];
        autostart   = type_q[TY_AUTO];
        irq         = |(evt_bits[1:0] & type_q[1:0]);
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_ST)      rd_data = status_q;
        else if (rd_addr == A_CT) rd_data[CTL_PAUSE] = chan_paused;
        else if (rd_addr == A_TY) rd_data = type_q;
    end
endmodule

// File: rtl/dmach_ctlreg_chk.sv
module dmach_ctlreg_chk #(
    parameter int AW        = 2,
    parameter int ADDR_STATUS = 0,
    parameter int ADDR_CTRL = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [7:0]    wr_data,
    input logic          ev_flag,
    input logic          ev_eol,
    input logic          chan_active,
    input logic          chan_pending,
    input logic          chan_paused,
    input logic          chan_run,
    input logic          irq,
    input logic [7:0]    status_q
);
    localparam logic [AW-1:0] A_ST = AW'(ADDR_STATUS);
    localparam logic [AW-1:0] A_CT = AW'(ADDR_CTRL);

    logic st_w, ct_w;
    assign st_w = wr_en && (wr_addr == A_ST);
    assign ct_w = wr_en && (wr_addr == A_CT);

    // R3
    a_r3_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_flag |=> (status_q[0] && status_q[2]));
    // R3
    a_r3_eol_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_eol |=> status_q[1]);
    // R2
    a_r2_w1c_eol: assert property (@(posedge clk) disable iff (!rst_n)
        (st_w && wr_data[1] && !ev_eol) |=> !status_q[1]);
    // R2
    a_r2_keep_state: assert property (@(posedge clk) disable iff (!rst_n)
        (st_w && !ev_eol) |=> (status_q[7:6] == $past(status_q[7:6])) && $stable(chan_pending));
    // R5
    a_r5_queue: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_w && wr_data[7] && !wr_data[6] && chan_active && !ev_eol) |=> (chan_active && chan_pending));
    // R6
    a_r6_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_w && wr_data[6]) |=> (!chan_active && !chan_pending));
    // R7
    a_r7_pause: assert property (@(posedge clk) disable iff (!rst_n)
        ct_w |=> (chan_paused == $past(wr_data[2])));
    // R9
    a_r9_consume: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_pending && ev_eol && !wr_en) |=> (chan_active && !chan_pending));
    // R10
    a_r10_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && st_w && (wr_data[1:0] == 2'b11) && !ev_flag && !ev_eol) |=> !irq);
    // R11
    a_r11_run: assert property (@(posedge clk) disable iff (!rst_n)
        chan_run |-> (chan_active && !chan_paused && !status_q[2]));
endmodule

bind dmach_ctlreg dmach_ctlreg_chk #(
    .AW(AW), .ADDR_STATUS(ADDR_STATUS), .ADDR_CTRL(ADDR_CTRL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .ev_flag     (ev_flag),
    .ev_eol      (ev_eol),
    .chan_active (chan_active),
    .chan_pending(chan_pending),
    .chan_paused (chan_paused),
    .chan_run    (chan_run),
    .irq         (irq),
    .status_q    (status_q)
);

// File: tb/sim_dmach_ctlreg.sv
`timescale 1ns/1ps
module sim_dmach_ctlreg;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] A_ST = 2'd0, A_CT = 2'd1, A_TY = 2'd2, A_NU = 2'd3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0, rd_data;
    logic ev_flag = 1'b0, ev_eol = 1'b0, ev_stop = 1'b0;
    logic chan_active, chan_pending, chan_paused, chan_halted, chan_run, ptr_reset, autostart, irq;
    logic [1:0] fmt;

    int n_chk = 0, n_bad = 0;
    logic pr;
    logic [7:0] v;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmach_ctlreg u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ev_flag(ev_flag), .ev_eol(ev_eol),
        .ev_stop(ev_stop), .chan_active(chan_active), .chan_pending(chan_pending),
        .chan_paused(chan_paused), .chan_halted(chan_halted), .chan_run(chan_run),
        .ptr_reset(ptr_reset), .fmt(fmt), .autostart(autostart), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // one clock of stimulus; pr holds ptr_reset seen during that cycle
    task automatic drive(input logic we, input logic [1:0] a, input logic [7:0] d,
                         input logic f, input logic e, input logic s, output logic p);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; ev_flag = f; ev_eol = e; ev_stop = s;
        #1 p = ptr_reset;
        @(negedge clk);
        wr_en = 1'b0; ev_flag = 1'b0; ev_eol = 1'b0; ev_stop = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_ST, v); chk("R1 status", v, 8'h00);
        rd(A_CT, v); chk("R1 control", v, 8'h00);
        rd(A_TY, v); chk("R1 type", v, 8'h00);
        chk("R1 outs", {3'b0, irq, chan_active, chan_pending, chan_run, ptr_reset}, 8'h00);

        // R8 sweep every type value
        for (int t = 0; t < 256; t++) begin
            drive(1, A_TY, 8'(t), 0, 0, 0, pr);
            rd(A_TY, v); chk("R8 type readback", v, 8'(t) & 8'hB3);
            chk("R8 fmt/auto", {5'b0, autostart, fmt}, {5'b0, 1'(t >> 7), 2'(t >> 4)});
        end
        drive(1, A_TY, 8'h00, 0, 0, 0, pr);

        // R12 unused offset
        drive(1, A_NU, 8'hFF, 0, 0, 0, pr);
        rd(A_NU, v); chk("R12 read unused", v, 8'h00);
        rd(A_ST, v); chk("R12 status untouched", v, 8'h00);
        rd(A_TY, v); chk("R12 type untouched", v, 8'h00);
        rd(A_CT, v); chk("R12 control untouched", v, 8'h00);

        // R2 / R3 / R10 sweep: preset x enables x clear mask
        for (int pre = 0; pre < 8; pre++) begin
            for (int en = 0; en < 4; en++) begin
                for (int m = 0; m < 8; m++) begin
                    logic [7:0] exp_s;
                    drive(1, A_ST, 8'h07, 0, 0, 0, pr);
                    drive(1, A_TY, 8'(en), 0, 0, 0, pr);
                    if (pre[0]) drive(0, A_ST, 8'h00, 1, 0, 0, pr);
                    if (pre[1]) drive(0, A_ST, 8'h00, 0, 1, 0, pr);
                    if (pre[2]) drive(0, A_ST, 8'h00, 0, 0, 1, pr);
                    if (pre[0] && !pre[2]) drive(1, A_ST, 8'h04, 0, 0, 0, pr);
                    rd(A_ST, v); chk("R3 preset", v, 8'(pre));
                    chk("R10 irq preset", {7'b0, irq}, {7'b0, |(2'(pre) & 2'(en))});
                    drive(1, A_ST, 8'(m) | 8'hF8, 0, 0, 0, pr);
                    exp_s = 8'(pre) & ~8'(m);
                    rd(A_ST, v); chk("R2 w1c", v, exp_s);
                    chk("R10 irq after clear", {7'b0, irq}, {7'b0, |(exp_s[1:0] & 2'(en))});
                end
            end
        end
        drive(1, A_ST, 8'h07, 0, 0, 0, pr);
        drive(1, A_TY, 8'h00, 0, 0, 0, pr);

        // R3 set beats clear in the same cycle
        drive(1, A_ST, 8'h07, 1, 1, 0, pr);
        rd(A_ST, v); chk("R3 set wins", v, 8'h07);
        drive(1, A_ST, 8'h07, 0, 0, 0, pr);

        // R4 start from idle clears halt and pause, pulses ptr_reset
        drive(0, A_ST, 8'h00, 0, 0, 1, pr);
        drive(1, A_CT, 8'h04, 0, 0, 0, pr);
        rd(A_ST, v); chk("R7 pause set", v, 8'h44);
        drive(1, A_CT, 8'h80, 0, 0, 0, pr);
        chk("R4 ptr_reset", {7'b0, pr}, 8'h01);
        rd(A_ST, v); chk("R4 active", v, 8'h80);
        chk("R11 run", {7'b0, chan_run}, 8'h01);

        // R5 start while active queues; R7 pause from same write
        drive(1, A_CT, 8'h84, 0, 0, 0, pr);
        chk("R5 no ptr_reset", {7'b0, pr}, 8'h00);
        rd(A_ST, v); chk("R5 queued", v, 8'hC8);
        rd(A_CT, v); chk("R7 control read", v, 8'h04);
        chk("R11 run paused", {7'b0, chan_run}, 8'h00);
        drive(1, A_ST, 8'hF8, 0, 0, 0, pr);
        rd(A_ST, v); chk("R2 upper ignored", v, 8'hC8);
        drive(1, A_CT, 8'h80, 0, 0, 0, pr);
        rd(A_ST, v); chk("R7 unpause", v, 8'h88);

        // R9 end of list consumes trigger
        drive(0, A_ST, 8'h00, 0, 1, 0, pr);
        chk("R9 consume ptr_reset", {7'b0, pr}, 8'h01);
        rd(A_ST, v); chk("R9 consume", v, 8'h82);
        drive(1, A_ST, 8'h02, 0, 0, 0, pr);

        // R9 auto-start restart
        drive(1, A_TY, 8'h80, 0, 0, 0, pr);
        drive(0, A_ST, 8'h00, 0, 1, 0, pr);
        chk("R9 auto ptr_reset", {7'b0, pr}, 8'h01);
        rd(A_ST, v); chk("R9 auto", v, 8'h82);
        drive(1, A_ST, 8'h02, 0, 0, 0, pr);

        // R9 finish
        drive(1, A_TY, 8'h00, 0, 0, 0, pr);
        drive(0, A_ST, 8'h00, 0, 1, 0, pr);
        chk("R9 finish no ptr_reset", {7'b0, pr}, 8'h00);
        rd(A_ST, v); chk("R9 finish", v, 8'h02);
        drive(1, A_ST, 8'h02, 0, 0, 0, pr);

        // R6 stop drops active and trigger
        drive(1, A_CT, 8'h80, 0, 0, 0, pr);
        drive(1, A_CT, 8'h80, 0, 0, 0, pr);
        rd(A_ST, v); chk("R5 queued again", v, 8'h88);
        drive(1, A_CT, 8'h40, 0, 0, 0, pr);
        rd(A_ST, v); chk("R6 stop", v, 8'h00);
        drive(1, A_CT, 8'hC0, 0, 0, 0, pr);
        rd(A_ST, v); chk("R6 stop wins", v, 8'h00);

        // R11 halt stops run
        drive(1, A_CT, 8'h80, 0, 0, 0, pr);
        chk("R11 run on", {7'b0, chan_run}, 8'h01);
        drive(0, A_ST, 8'h00, 0, 0, 1, pr);
        chk("R11 halted", {6'b0, chan_halted, chan_run}, 8'h02);
        rd(A_ST, v); chk("R3 stop event", v, 8'h84);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule